// File: doc/BRIEF.md
# Multi-Hit Edge Detector and Encoder

This block serves one timing channel. Every reference clock cycle it takes a 16-bit snapshot of the channel input. Bit i of the snapshot is the input level at phase i/16 of that cycle. The block looks for a rising and a falling transition in the snapshot, including a transition across the boundary with the previous snapshot. It encodes each transition it finds as a sample index and an edge-type bit, and adds the value of a free-running coarse cycle counter. The resulting records are stored only when a transition was found. Cycles in which the input is quiet cost no storage.

Records gather in a small first-in first-out store with a fall-through read port. Downstream logic watches `empty`, reads `rd_data`, and strobes `pop` to advance. A select input chooses which edge types are kept. A sticky `hit_lost` flag reports any record that was discarded.

Top module: `edge_hit_encoder`

## Requirements
- R1: After reset, `empty` is 1 and `hit_lost` is 0. The coarse counter restarts at 0, and the sample taken before the first snapshot is treated as 0.
- R2: A leading edge, meaning sample i-1 is 0 and sample i is 1, produces a record with edge bit 1 and fine code i.
- R3: A trailing edge, meaning sample i-1 is 1 and sample i is 0, produces a record with edge bit 0 and fine code i.
- R4: Fine code 0 is used for an edge between bit 15 of the previous snapshot and bit 0 of the current snapshot.
- R5: A snapshot with no enabled edge writes nothing into the store.
- R6: When a snapshot holds several edges of one type, only the earliest edge of that type is recorded.
- R7: When a snapshot holds an enabled edge of each type, two records are stored in consecutive cycles, and the earlier edge comes first.
- R8: `edge_sel` controls which edge types are recorded. Bit 0 enables leading edges and bit 1 enables trailing edges; 2'b00 records nothing.
- R9: A record is 24 bits, laid out as {edge bit, coarse[18:0], fine[3:0]}. The coarse field is the counter value in the cycle the snapshot was presented. The counter advances by one every cycle.
- R10: The store holds 32 records and returns them in arrival order. The head record appears on `rd_data` while `empty` is 0, and `pop` advances to the next one. A `pop` while `empty` is 1 has no effect.
- R11: A record that arrives while the store is full is discarded and sets `hit_lost`. The flag stays set until reset.
- R12: A snapshot with two recorded edges can arrive while a second record is still pending. In that case the later edge of the new snapshot is discarded and `hit_lost` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one snapshot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_sel | input | 2 | Edge-type enables (bit 0 leading, bit 1 trailing) |
| sample_word | input | 16 | Snapshot of the channel input, bit i at phase i/16 |
| pop | input | 1 | Advance the read port by one record |
| rd_data | output | 24 | Head record {edge, coarse, fine} |
| empty | output | 1 | Store holds no record |
| hit_lost | output | 1 | Sticky flag: a record was discarded |

## Verification
The bench builds the block with its default parameters: 16 samples per cycle, a 19-bit coarse counter and a 32-entry store. With a 32-entry store, filling the store, overflowing it and draining it take only a few dozen cycles. Coarse wrap-around needs 2^19 cycles and is not reached with these values. The recorded coarse fields are still compared exactly against a count of cycles since reset. The 16-bit snapshot allows directed patterns for every fine-code position of interest, including the boundary with the previous snapshot.

// File: rtl/edge_hit_encoder.sv
module edge_hit_encoder #(
  parameter int SAMPLES  = 16,
  parameter int COARSE_W = 19,
  parameter int DEPTH    = 32
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [1:0]                                  edge_sel,
  input  logic [SAMPLES-1:0]                          sample_word,
  input  logic                                        pop,
  output logic [1+COARSE_W+$clog2(SAMPLES)-1:0]       rd_data,
  output logic                                        empty,
  output logic                                        hit_lost
);
  localparam int FW = $clog2(SAMPLES);
  localparam int RW = 1 + COARSE_W + FW;
  localparam int AW = $clog2(DEPTH);

  logic [COARSE_W-1:0] coarse;
  logic                prev_msb;
  logic [SAMPLES:0]    ext;
  logic                rise_hit, fall_hit;
  logic [FW-1:0]       rise_pos, fall_pos;

  assign ext = {sample_word, prev_msb};

  always_comb begin
    rise_hit = 1'b0;
    fall_hit = 1'b0;
    rise_pos = '0;
    fall_pos = '0;
    for (int i = SAMPLES - 1; i >= 0; i--) begin
      if (ext[i+1] && !ext[i]) begin
        rise_hit = 1'b1;
        rise_pos = FW'(i);
      end
      if (!ext[i+1] && ext[i]) begin
        fall_hit = 1'b1;
        fall_pos = FW'(i);
      end
    end
  end

  logic          lead_en, trail_en, two_new, any_new, rise_first;
  logic [RW-1:0] rec_r, rec_f, first_rec, second_rec;

  assign lead_en    = edge_sel[0] & rise_hit;
  assign trail_en   = edge_sel[1] & fall_hit;
  assign two_new    = lead_en & trail_en;
  assign any_new    = lead_en | trail_en;
  assign rise_first = rise_pos < fall_pos;
  assign rec_r      = {1'b1, coarse, rise_pos};
  assign rec_f      = {1'b0, coarse, fall_pos};
  assign first_rec  = two_new ? (rise_first ? rec_r : rec_f) : (lead_en ? rec_r : rec_f);
  assign second_rec = rise_first ? rec_f : rec_r;

  logic          hold_v;
  logic [RW-1:0] hold_d;
  logic          wr_req, wr_en, rd_en, full, collide;
  logic [RW-1:0] wr_data;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic [RW-1:0] mem [DEPTH];

  assign wr_req  = hold_v | any_new;
  assign wr_data = hold_v ? hold_d : first_rec;
  assign collide = hold_v & two_new;
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign wr_en   = wr_req & ~full;
  assign rd_en   = pop & ~empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse   <= '0;
      prev_msb <= 1'b0;
      hold_v   <= 1'b0;
      hold_d   <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      hit_lost <= 1'b0;
    end else begin
      coarse   <= coarse + 1'b1;
      prev_msb <= sample_word[SAMPLES-1];
      if (hold_v) begin
        hold_v <= any_new;
        hold_d <= first_rec;
      end else begin
        hold_v <= two_new;
        hold_d <= second_rec;
      end
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(rd_en);
      if ((wr_req && full) || collide) hit_lost <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !wr_req) |=> empty);

  a_r11_sticky_lost: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lost |=> hit_lost);

  a_r11_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !pop) |=> (hit_lost && full));

  a_r5_quiet_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_v && !lead_en && !trail_en && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: tb/edge_hit_encoder_bench.sv
module edge_hit_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  edge_sel = 2'b11;
  logic [15:0] sample_word = '0;
  logic        pop = 1'b0;
  logic [23:0] rd_data;
  logic        empty, hit_lost;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  edge_hit_encoder u_edge_hit_encoder (
    .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .sample_word(sample_word),
    .pop(pop), .rd_data(rd_data), .empty(empty), .hit_lost(hit_lost)
  );

  function automatic logic [23:0] rec(input logic t, input int c, input int f);
    return {t, 19'(c), 4'(f)};
  endfunction

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input logic [15:0] w, input logic p);
    sample_word = w;
    pop = p;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sample_word = '0;
    pop = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic pop_expect(input string tag, input logic [23:0] exp);
    check({tag, " not empty"}, 24'(empty), 24'(0));
    check(tag, rd_data, exp);
    tick(16'h0000, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 empty after reset", 24'(empty), 24'(1));
    check("R1 hit_lost after reset", 24'(hit_lost), 24'(0));
  endtask

  task automatic t_lead();
    int c;
    do_reset();
    edge_sel = 2'b01;
    c = cyc;
    tick(16'h00F0, 1'b0);
    tick(16'h0000, 1'b0);
    pop_expect("R2 leading at 4", rec(1'b1, c, 4));
    check("R8 trailing disabled", 24'(empty), 24'(1));
  endtask

  task automatic t_trail();
    int c;
    do_reset();
    edge_sel = 2'b10;
    tick(16'hFFFF, 1'b0);
    c = cyc;
    tick(16'h0007, 1'b0);
    tick(16'h0000, 1'b0);
    pop_expect("R3 trailing at 3", rec(1'b0, c, 3));
    check("R8 leading disabled", 24'(empty), 24'(1));
  endtask

  task automatic t_boundary();
    int c;
    do_reset();
    edge_sel = 2'b11;
    c = cyc;
    tick(16'h8000, 1'b0);
    tick(16'h0000, 1'b0);
    pop_expect("R2 leading at 15", rec(1'b1, c, 15));
    pop_expect("R4 boundary trailing", rec(1'b0, c + 1, 0));
    check("R4 nothing more", 24'(empty), 24'(1));
  endtask

  task automatic t_none();
    do_reset();
    edge_sel = 2'b00;
    tick(16'h0F0F, 1'b0);
    tick(16'hF0F0, 1'b0);
    check("R8 select 00 records nothing", 24'(empty), 24'(1));
    edge_sel = 2'b11;
    tick(16'hFFFF, 1'b0);
    tick(16'hFFFF, 1'b0);
    check("R5 steady input records nothing", 24'(empty), 24'(1));
  endtask

  task automatic t_multi();
    int c;
    do_reset();
    edge_sel = 2'b01;
    c = cyc;
    tick(16'h0505, 1'b0);
    tick(16'h0000, 1'b0);
    pop_expect("R6 earliest leading only", rec(1'b1, c, 0));
    check("R6 single record", 24'(empty), 24'(1));
  endtask

  task automatic t_pair();
    int c1, c2;
    do_reset();
    edge_sel = 2'b11;
    c1 = cyc;
    tick(16'h00F0, 1'b0);
    check("R7 first record present", 24'(empty), 24'(0));
    check("R7 leading first", rd_data, rec(1'b1, c1, 4));
    tick(16'h0000, 1'b1);
    check("R7 trailing next cycle", rd_data, rec(1'b0, c1, 8));
    tick(16'h0000, 1'b1);
    check("R7 drained", 24'(empty), 24'(1));
    edge_sel = 2'b01;
    c1 = cyc;
    tick(16'h8000, 1'b0);
    edge_sel = 2'b11;
    c2 = cyc;
    tick(16'h0FF0, 1'b0);
    tick(16'h0000, 1'b0);
    pop_expect("R9 leading at 15", rec(1'b1, c1, 15));
    pop_expect("R7 trailing first", rec(1'b0, c2, 0));
    pop_expect("R7 leading second", rec(1'b1, c2, 4));
    check("R6 later trailing ignored", 24'(empty), 24'(1));
  endtask

  task automatic t_full();
    int c;
    do_reset();
    edge_sel = 2'b01;
    c = cyc;
    for (int i = 0; i < 32; i++) tick(16'h0001, 1'b0);
    check("R11 no loss at exactly full", 24'(hit_lost), 24'(0));
    tick(16'h0001, 1'b0);
    check("R11 loss when full", 24'(hit_lost), 24'(1));
    for (int i = 0; i < 32; i++) pop_expect("R10 R9 ordered record", rec(1'b1, c + i, 0));
    check("R10 empty after drain", 24'(empty), 24'(1));
    tick(16'h0000, 1'b1);
    check("R10 pop on empty ignored", 24'(empty), 24'(1));
    check("R11 flag sticky", 24'(hit_lost), 24'(1));
    do_reset();
    check("R1 flag cleared by reset", 24'(hit_lost), 24'(0));
  endtask

  task automatic t_collide();
    int c;
    do_reset();
    edge_sel = 2'b11;
    c = cyc;
    tick(16'h00F0, 1'b0);
    check("R12 no loss yet", 24'(hit_lost), 24'(0));
    tick(16'h0F00, 1'b0);
    check("R12 loss flagged", 24'(hit_lost), 24'(1));
    tick(16'h0000, 1'b0);
    pop_expect("R12 rec 1", rec(1'b1, c, 4));
    pop_expect("R12 rec 2", rec(1'b0, c, 8));
    pop_expect("R12 rec 3", rec(1'b1, c + 1, 8));
    check("R12 later edge dropped", 24'(empty), 24'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lead();
    t_trail();
    t_boundary();
    t_none();
    t_multi();
    t_pair();
    t_full();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule